// File: doc/BRIEF.md
# Time-Slot Coincidence Multiplier

This block forms the product of two signed-magnitude operands without a parallel multiplier. Each operand magnitude is a 4-bit value read as a fraction in fifteenths, from 0/15 to 15/15. A window of 15 clock slots carries out one multiplication. During the window the input magnitude becomes a single high run that starts in the first slot and covers as many slots as the value. The weight magnitude becomes a fixed pattern of active slots, spread evenly over the window. One AND gate combines the two streams, and a counter adds up the slots where both are high. At the end of the window the count is the product in fifteenths, already rounded to the nearest step.

The sign travels on a separate path: the product is negative when exactly one operand sign is set. A product that rounds to zero is always reported as positive. A user pulses `start` with the operands present and waits for `done`. The result then stays on the outputs until the next accepted start. Adding several products together and applying an activation function are left to the surrounding logic.

Top module: `tsmul_top`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `prod_mag` and `prod_neg` are all 0.
- R2: A `start` sampled high while `busy` is 0 captures all four operand inputs and raises `busy`. `done` goes high on the 15th rising edge after that edge and stays high for exactly one cycle. `busy` is low again in that same cycle.
- R3: When `done` is high, `prod_mag` equals round(x·w/15), computed as (2·x·w+15) div 30, for every pair of magnitudes x and w from 0 to 15. For example, 8 and 5 give 3.
- R4: When `done` is high, the absolute difference between 15·`prod_mag` and x·w is at most 7, so the error stays below about 0.031.
- R5: When `done` is high and `prod_mag` is nonzero, `prod_neg` equals `x_neg` XOR `w_neg`.
- R6: A zero input magnitude or a zero weight magnitude gives `prod_mag` = 0 and `prod_neg` = 0, whatever the sign inputs are. More generally, `prod_neg` is 0 whenever `prod_mag` is 0 at `done`.
- R7: A `start` pulse sampled while `busy` is 1 is ignored. The running window completes on time with the operands it captured first.
- R8: After `done`, `prod_mag` and `prod_neg` keep their values until the next accepted start.
- R9: At full scale, 15 times w gives w and x times 15 gives x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication window; accepted only when idle |
| x_mag | input | 4 | Input magnitude in fifteenths |
| x_neg | input | 1 | Input sign, 1 means negative |
| w_mag | input | 4 | Weight magnitude in fifteenths |
| w_neg | input | 1 | Weight sign, 1 means negative |
| busy | output | 1 | A window is in progress |
| done | output | 1 | One-cycle pulse when the result becomes valid |
| prod_mag | output | 4 | Rounded product magnitude in fifteenths |
| prod_neg | output | 1 | Product sign, 1 means negative |

## Verification
The bench runs every one of the 256 magnitude pairs with random signs. This catches any wrong slot in a weight pattern, because such a fault breaks the rounding for at least one input length. Directed cases cover:
- zero operands under all four sign combinations, which tells a rounded-to-zero product apart from a sign leak;
- the full-scale rows and columns, which expose an off-by-one in the input run length or in the slot count;
- a start pulse injected in the middle of a window, which separates a design that ignores it from one that restarts or recaptures the operands.

A burst of random operand sets, together with a hold check after `done`, shows that results stay put between windows.

// File: rtl/tsmul_pkg.sv
package tsmul_pkg;

    localparam int DEF_MAG_W = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_t;

    // Rounded share of n slots out of slots for weight w (no ties occur: slots is odd)
    function automatic int round_share(input int n, input int w, input int slots);
        return (2 * n * w + slots) / (2 * slots);
    endfunction

    // Slot pattern for weight w: slot k is active when the rounded share steps up there
    function automatic logic [63:0] weight_pattern(input int w, input int slots);
        logic [63:0] pat;
        pat = '0;
        for (int k = 0; k < slots; k++) begin
            if (round_share(k + 1, w, slots) != round_share(k, w, slots))
                pat[k] = 1'b1;
        end
        return pat;
    endfunction

endpackage

// File: rtl/tsmul_sequencer.sv
module tsmul_sequencer
    import tsmul_pkg::*;
#(
    parameter int MAG_W = DEF_MAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             accept,
    output logic             slot_valid,
    output logic [MAG_W-1:0] slot_idx,
    output logic             busy,
    output logic             done
);
    localparam int SLOTS = (1 << MAG_W) - 1;
    localparam logic [MAG_W-1:0] LAST_SLOT = MAG_W'(SLOTS - 1);

    seq_state_t state_q;
    logic [MAG_W-1:0] idx_q;

    assign busy       = (state_q == SEQ_RUN);
    assign slot_valid = busy;
    assign slot_idx   = idx_q;
    assign done       = (state_q == SEQ_FIN);
    assign accept     = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_RUN: begin
                    if (idx_q == LAST_SLOT) begin
                        state_q <= SEQ_FIN;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    if (accept) begin
                        state_q <= SEQ_RUN;
                        idx_q   <= '0;
                    end else begin
                        state_q <= SEQ_IDLE;
                    end
                end
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy) && ($past(idx_q) == LAST_SLOT)); // R2
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (busy && idx_q != LAST_SLOT) |=> busy && (idx_q == $past(idx_q) + 1'b1)); // R7

endmodule

// File: rtl/tsmul_pulse_conv.sv
module tsmul_pulse_conv
    import tsmul_pkg::*;
#(
    parameter int MAG_W = DEF_MAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MAG_W-1:0] mag,
    input  logic             slot_valid,
    input  logic [MAG_W-1:0] slot_idx,
    output logic             pulse
);
    logic [MAG_W-1:0] mag_q;

    always_ff @(posedge clk) begin
        if (rst)
            mag_q <= '0;
        else if (load)
            mag_q <= mag;
    end

    // High run from the first slot, one slot per unit of magnitude
    assign pulse = slot_valid && (slot_idx < mag_q);

    AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && $past(slot_valid) && !$past(pulse)) |-> !pulse); // R3

endmodule

// File: rtl/tsmul_weight_enc.sv
module tsmul_weight_enc
    import tsmul_pkg::*;
#(
    parameter int MAG_W = DEF_MAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MAG_W-1:0] mag,
    input  logic             slot_valid,
    input  logic [MAG_W-1:0] slot_idx,
    output logic             active
);
    localparam int SLOTS = (1 << MAG_W) - 1;
    localparam int NVAL  = 1 << MAG_W;

    logic [SLOTS-1:0] pat_tbl [NVAL];
    logic [SLOTS-1:0] pat_q;

    for (genvar v = 0; v < NVAL; v++) begin : g_pat
        localparam logic [63:0] PAT = weight_pattern(v, SLOTS);
        assign pat_tbl[v] = PAT[SLOTS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            pat_q <= '0;
        else if (load)
            pat_q <= pat_tbl[mag];
    end

    assign active = slot_valid && pat_q[slot_idx];

    AST_PATTERN_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        load |=> ($countones(pat_q) == $past(int'(mag)))); // R9

endmodule

// File: rtl/tsmul_coinc_cnt.sv
module tsmul_coinc_cnt
    import tsmul_pkg::*;
#(
    parameter int MAG_W = DEF_MAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             in_a,
    input  logic             in_b,
    output logic [MAG_W-1:0] count
);
    localparam int SLOTS = (1 << MAG_W) - 1;

    logic hit;
    logic [MAG_W-1:0] cnt_q;

    assign hit   = in_a & in_b;
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (hit)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        hit |-> (int'(cnt_q) < SLOTS)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!clear && !$past(clear)) |-> (cnt_q - $past(cnt_q) <= MAG_W'(1))); // R3

endmodule

// File: rtl/tsmul_top.sv
module tsmul_top
    import tsmul_pkg::*;
#(
    parameter int MAG_W = DEF_MAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MAG_W-1:0] x_mag,
    input  logic             x_neg,
    input  logic [MAG_W-1:0] w_mag,
    input  logic             w_neg,
    output logic             busy,
    output logic             done,
    output logic [MAG_W-1:0] prod_mag,
    output logic             prod_neg
);
    logic             accept;
    logic             slot_valid;
    logic [MAG_W-1:0] slot_idx;
    logic             x_pulse;
    logic             w_active;
    logic [MAG_W-1:0] count;
    logic             sign_q;
    logic             x_zero_q;
    logic             w_zero_q;

    tsmul_sequencer #(.MAG_W(MAG_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .accept(accept),
        .slot_valid(slot_valid), .slot_idx(slot_idx), .busy(busy), .done(done)
    );

    tsmul_pulse_conv #(.MAG_W(MAG_W)) u_xconv (
        .clk(clk), .rst(rst), .load(accept), .mag(x_mag),
        .slot_valid(slot_valid), .slot_idx(slot_idx), .pulse(x_pulse)
    );

    tsmul_weight_enc #(.MAG_W(MAG_W)) u_wenc (
        .clk(clk), .rst(rst), .load(accept), .mag(w_mag),
        .slot_valid(slot_valid), .slot_idx(slot_idx), .active(w_active)
    );

    tsmul_coinc_cnt #(.MAG_W(MAG_W)) u_cnt (
        .clk(clk), .rst(rst), .clear(accept),
        .in_a(x_pulse), .in_b(w_active), .count(count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sign_q   <= 1'b0;
            x_zero_q <= 1'b0;
            w_zero_q <= 1'b0;
        end else if (accept) begin
            sign_q   <= x_neg ^ w_neg;
            x_zero_q <= (x_mag == '0);
            w_zero_q <= (w_mag == '0);
        end
    end

    assign prod_mag = count;
    assign prod_neg = sign_q && (count != '0);

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (done && (x_zero_q || w_zero_q)) |-> (prod_mag == '0) && !prod_neg); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        ($past(done) && !$past(accept) && !busy) |-> $stable(prod_mag) && $stable(prod_neg)); // R8
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(sign_q)); // R7

endmodule

// File: tb/tsmul_top_tb.sv
module tsmul_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] x_mag = '0;
    logic       x_neg = 1'b0;
    logic [3:0] w_mag = '0;
    logic       w_neg = 1'b0;
    logic       busy;
    logic       done;
    logic [3:0] prod_mag;
    logic       prod_neg;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tsmul_top u_dut (
        .clk(clk), .rst(rst), .start(start),
        .x_mag(x_mag), .x_neg(x_neg), .w_mag(w_mag), .w_neg(w_neg),
        .busy(busy), .done(done), .prod_mag(prod_mag), .prod_neg(prod_neg)
    );

    function automatic int exp_mag(input int x, input int w);
        return (2 * x * w + 15) / 30;
    endfunction

    function automatic bit exp_neg(input int x, input int w, input bit xn, input bit wn);
        return (xn ^ wn) && (exp_mag(x, w) != 0);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Runs one window; optionally injects a start with other operands mid-window
    task automatic run_mul(input int x, input bit xn, input int w, input bit wn,
                           input bit inject, input bit full);
        int lat;
        int em;
        bit en;
        @(negedge clk);
        start = 1'b1; x_mag = 4'(x); x_neg = xn; w_mag = 4'(w); w_neg = wn;
        @(negedge clk);
        start = 1'b0;
        if (full) check("R2 busy after start", int'(busy), 1);
        lat = 0;
        while (!done && lat < 40) begin
            if (inject && lat == 4) begin
                start = 1'b1; x_mag = 4'(15 - x); x_neg = ~xn; w_mag = 4'(15 - w); w_neg = wn;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        em = exp_mag(x, w);
        en = exp_neg(x, w, xn, wn);
        if (full || inject) check("R2 latency", lat, 15);
        check(inject ? "R7 product after ignored start" : "R3 product", int'(prod_mag), em);
        if (done) begin
            checks++;
            if ((15 * int'(prod_mag) - x * w > 7) || (x * w - 15 * int'(prod_mag) > 7)) begin
                errors++;
                $display("FAIL R4: actual=%0d expected=within 7/225 of %0d/225", prod_mag, x * w);
            end
        end
        check((em == 0) ? "R6 sign of zero product" : "R5 sign", int'(prod_neg), int'(en));
        if (full) begin
            check("R2 busy low at done", int'(busy), 0);
            @(negedge clk);
            check("R2 done one cycle", int'(done), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 prod_mag", int'(prod_mag), 0);
        check("R1 prod_neg", int'(prod_neg), 0);

        // R3 directed example
        run_mul(8, 1'b0, 5, 1'b1, 1'b0, 1'b1);
        check("R3 example 8x5", int'(prod_mag), 3);

        // R6 zero operands under all sign combinations
        for (int s = 0; s < 4; s++) begin
            run_mul(0, s[0], 13, s[1], 1'b0, 1'b0);
            check("R6 zero input mag", int'(prod_mag), 0);
            run_mul(11, s[0], 0, s[1], 1'b0, 1'b0);
            check("R6 zero weight sign", int'(prod_neg), 0);
        end

        // R9 full scale rows and columns
        for (int v = 0; v < 16; v++) begin
            run_mul(15, 1'b0, v, 1'b0, 1'b0, 1'b0);
            check("R9 full input", int'(prod_mag), v);
            run_mul(v, 1'b1, 15, 1'b0, 1'b0, 1'b0);
            check("R9 full weight", int'(prod_mag), v);
        end

        // R7 start during a busy window
        run_mul(8, 1'b1, 5, 1'b0, 1'b1, 1'b0);
        run_mul(3, 1'b0, 12, 1'b0, 1'b1, 1'b0);

        // R8 hold after done
        run_mul(9, 1'b1, 7, 1'b0, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        check("R8 hold mag", int'(prod_mag), exp_mag(9, 7));
        check("R8 hold sign", int'(prod_neg), int'(exp_neg(9, 7, 1'b1, 1'b0)));

        // R3 R4 R5 exhaustive magnitudes with random signs
        for (int x = 0; x < 16; x++) begin
            for (int w = 0; w < 16; w++) begin
                run_mul(x, 1'($urandom), w, 1'($urandom), 1'b0, (x == w));
            end
        end

        // Random burst with R2 timing checks
        for (int i = 0; i < 60; i++) begin
            run_mul(int'($urandom % 16), 1'($urandom), int'($urandom % 16), 1'($urandom), 1'b0, 1'b1);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule